// File: doc/BRIEF.md
# Predicated find-first mask generator

The block turns an N-bit source mask into an N-bit destination mask by scanning the source from bit 0 upward and marking bits relative to the first set source bit it finds. Three marking modes are offered: mark every bit below the first set bit, mark every bit up to and including it, or mark that bit alone. The result is registered, so a new destination appears on `dst_o` one clock after the inputs are presented.

The scan can run under a predicate. When the predicate is enabled, a bit whose predicate bit is 0 is inactive. It is skipped and takes the value of the old destination supplied on `old_dst_i`. Each bit position is one step of a small per-bit state machine with two states. SEARCH means no set source bit has been met yet. DONE means the first set bit has been passed. The transition SEARCH→DONE fires on an active set source bit. The transition DONE→SEARCH (re-entry) fires when the predicate is enabled and the scan reaches an active bit. An inactive bit leaves the state as it is (hold). The chain starts in SEARCH when the predicate is off or predicate bit 0 is set, and in DONE otherwise.

Top module: `ffm_mask_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset before any capture, `dst_o` is all zeros.
- R2: `dst_o` takes the result computed from the inputs present at a rising clock edge, and shows it after that edge. The latency is one cycle.
- R3: Mode 2'b00 (before-first) with the predicate off gives 1 at every bit below the lowest set source bit, and 0 at that bit and above.
- R4: With the predicate off and a zero source, mode 2'b00 and mode 2'b01 give all ones, and mode 2'b10 gives all zeros.
- R5: Mode 2'b01 (including-first) with the predicate off gives 1 at every bit up to and including the lowest set source bit, and 0 above it.
- R6: Mode 2'b10 (only-first) with the predicate off gives 1 only at the lowest set source bit. At most one output bit is set.
- R7: With `pred_en_i` high, every bit whose `pred_i` bit is 0 is copied from `old_dst_i`.
- R8: With `pred_en_i` high, every active bit re-enters SEARCH. An active bit is therefore ~src in mode 2'b00, 1 in mode 2'b01 and src in mode 2'b10. For example, with predicate 8'b11000011, source 8'b10010100 and mode 2'b00, the result is bit7=0, bit6=1, bits1..0=1, and bits 5..2 come from the old destination.
- R9: Mode 2'b11 is reserved and passes `old_dst_i` through unchanged on all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N | Source mask to be scanned |
| pred_i | input | N | Predicate mask; 1 = active bit |
| pred_en_i | input | 1 | Enables predication |
| mode_i | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 reserved |
| old_dst_i | input | N | Previous destination, kept on inactive bits |
| dst_o | output | N | Registered new destination |

## Verification
Within one cycle, the hold of inactive bits and the re-entry into SEARCH at active bits both occur. The first copies `old_dst_i`, and the second restarts marking. The bench provokes both by driving interleaved predicate patterns where active and inactive bits alternate around set source bits, with the old destination set to the complement of the expected active result. A wrong hold or a missed re-entry then flips a visible bit. Each captured word is judged whole against a bench model that marks active bits per mode and copies inactive ones.

// File: rtl/ffm_pkg.sv
package ffm_pkg;

    typedef enum logic [1:0] {
        MODE_BEFORE  = 2'b00,
        MODE_INCL    = 2'b01,
        MODE_ONLY    = 2'b10,
        MODE_RSVD    = 2'b11
    } ffm_mode_e;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_DONE   = 1'b1
    } ffm_state_e;

endpackage

// File: rtl/ffm_cell.sv
module ffm_cell
    import ffm_pkg::*;
(
    input  logic       active_i,
    input  logic       src_i,
    input  logic       old_i,
    input  logic       pred_en_i,
    input  ffm_mode_e  mode_i,
    input  ffm_state_e st_i,
    output logic       bit_o,
    output ffm_state_e st_o
);

    ffm_state_e st_eff;

    always_comb begin
        // Re-entry: with predication, every active bit restarts the search.
        st_eff = (pred_en_i && active_i) ? ST_SEARCH : st_i;
    end

    always_comb begin
        bit_o = old_i;
        st_o  = st_i;
        if (active_i) begin
            unique case (st_eff)
                ST_SEARCH: begin
                    unique case (mode_i)
                        MODE_BEFORE: bit_o = ~src_i;
                        MODE_INCL:   bit_o = 1'b1;
                        MODE_ONLY:   bit_o = src_i;
                        default:     bit_o = old_i;
                    endcase
                    st_o = src_i ? ST_DONE : ST_SEARCH;
                end
                ST_DONE: begin
                    bit_o = 1'b0;
                    st_o  = ST_DONE;
                end
                default: begin
                    bit_o = old_i;
                    st_o  = st_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/ffm_chain.sv
module ffm_chain
    import ffm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pred_i,
    input  logic         pred_en_i,
    input  ffm_mode_e    mode_i,
    input  logic [N-1:0] old_i,
    output logic [N-1:0] res_o
);

    ffm_state_e st [N+1];

    assign st[0] = (!pred_en_i || pred_i[0]) ? ST_SEARCH : ST_DONE;

    for (genvar i = 0; i < N; i++) begin : g_cell
        ffm_cell u_cell (
            .active_i  (!pred_en_i || pred_i[i]),
            .src_i     (src_i[i]),
            .old_i     (old_i[i]),
            .pred_en_i (pred_en_i),
            .mode_i    (mode_i),
            .st_i      (st[i]),
            .bit_o     (res_o[i]),
            .st_o      (st[i+1])
        );
    end

endmodule

// File: rtl/ffm_mask_gen.sv
module ffm_mask_gen
    import ffm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pred_i,
    input  logic         pred_en_i,
    input  logic [1:0]   mode_i,
    input  logic [N-1:0] old_dst_i,
    output logic [N-1:0] dst_o
);

    localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

    ffm_mode_e    mode;
    logic [N-1:0] chain_res;
    logic [N-1:0] next_dst;

    assign mode = ffm_mode_e'(mode_i);

    ffm_chain #(.N(N)) u_chain (
        .src_i     (src_i),
        .pred_i    (pred_i),
        .pred_en_i (pred_en_i),
        .mode_i    (mode),
        .old_i     (old_dst_i),
        .res_o     (chain_res)
    );

    always_comb begin
        next_dst = (mode == MODE_RSVD) ? old_dst_i : chain_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dst_o <= '0;
        else        dst_o <= next_dst;
    end

    // R7
    inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_en_i && mode_i != 2'b11) |=> (((dst_o ^ $past(old_dst_i)) & ~$past(pred_i)) == '0));

    // R9
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> (dst_o == $past(old_dst_i)));

    // R6
    only_first_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && !pred_en_i) |=> $onehot0(dst_o));

    // R4
    empty_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && !pred_en_i && src_i == '0) |=> (dst_o == ALL_ONES));

    // R5
    incl_hits_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && !pred_en_i && src_i != '0) |=> ($countones(dst_o & $past(src_i)) == 1));

    // R3
    before_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && !pred_en_i) |=> ((dst_o & $past(src_i)) == '0));

endmodule

// File: tb/ffm_mask_gen_tb.sv
module ffm_mask_gen_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [N-1:0] pred = '0;
    logic         pen = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [N-1:0] old = '0;
    logic [N-1:0] dst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ffm_mask_gen #(.N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .pred_i    (pred),
        .pred_en_i (pen),
        .mode_i    (mode),
        .old_dst_i (old),
        .dst_o     (dst)
    );

    function automatic logic [N-1:0] model(logic [N-1:0] s, logic [N-1:0] p,
                                           logic e, logic [1:0] m, logic [N-1:0] o);
        logic [N-1:0] r;
        int first;
        if (m == 2'b11) return o;
        if (e) begin
            for (int i = 0; i < N; i++) begin
                if (!p[i])            r[i] = o[i];
                else if (m == 2'b00)  r[i] = ~s[i];
                else if (m == 2'b01)  r[i] = 1'b1;
                else                  r[i] = s[i];
            end
            return r;
        end
        first = N;
        for (int i = N - 1; i >= 0; i--) if (s[i]) first = i;
        for (int i = 0; i < N; i++) begin
            if (m == 2'b00)      r[i] = (i < first);
            else if (m == 2'b01) r[i] = (i <= first);
            else                 r[i] = (i == first);
        end
        return r;
    endfunction

    task automatic check(logic [N-1:0] exp, string req);
        checks++;
        if (dst !== exp) begin
            errors++;
            $display("FAIL %s: dst=%b expected=%b", req, dst, exp);
        end
    endtask

    // drive at negedge, check at the following negedge (one register)
    task automatic apply(logic [N-1:0] s, logic [N-1:0] p, logic e,
                         logic [1:0] m, logic [N-1:0] o, string req);
        logic [N-1:0] exp;
        src = s; pred = p; pen = e; mode = m; old = o;
        exp = model(s, p, e, m, o);
        @(negedge clk);
        check(exp, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: dst=%b expected=completion", dst);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        src = 8'hFF; mode = 2'b01;
        repeat (3) @(negedge clk);
        check('0, "R1");
        rst_n = 1'b1;
        src = '0; mode = 2'b00;
        // R2: value shows one edge after inputs
        apply(8'b1001_0100, '0, 1'b0, 2'b00, '0, "R2");
        // R3 example
        apply(8'b1001_0100, '0, 1'b0, 2'b00, 8'hA5, "R3");
        // R5 example
        apply(8'b1001_0100, '0, 1'b0, 2'b01, 8'hA5, "R5");
        // R6 example
        apply(8'b1001_0100, '0, 1'b0, 2'b10, 8'hA5, "R6");
        check(8'b0000_0100, "R6");
        // R4 zero source
        apply('0, '0, 1'b0, 2'b00, 8'h3C, "R4");
        check(8'hFF, "R4");
        apply('0, '0, 1'b0, 2'b01, 8'h3C, "R4");
        apply('0, '0, 1'b0, 2'b10, 8'h3C, "R4");
        check(8'h00, "R4");
        // top-bit and bit-0 boundaries
        apply(8'b1000_0000, '0, 1'b0, 2'b00, '0, "R3");
        apply(8'b0000_0001, '0, 1'b0, 2'b01, '0, "R5");
        // R8 example, predicated before-first
        apply(8'b1001_0100, 8'b1100_0011, 1'b1, 2'b00, 8'b0010_1000, "R8");
        check(8'b0110_1011, "R8");
        // R7 inactive bits vs complemented old
        apply(8'b0101_0101, 8'b0101_0101, 1'b1, 2'b10, 8'hAA, "R7");
        apply(8'b0110_0110, 8'b1010_1010, 1'b1, 2'b01, 8'h55, "R7");
        apply(8'b1111_0000, 8'b0000_0000, 1'b1, 2'b00, 8'h96, "R7");
        // R9 reserved
        apply(8'b1001_0100, 8'hFF, 1'b1, 2'b11, 8'hC3, "R9");
        apply(8'b0000_0001, '0, 1'b0, 2'b11, 8'h5A, "R9");
        for (int k = 0; k < 400; k++) begin
            logic e;
            logic [1:0] m;
            e = 1'($urandom);
            m = 2'($urandom);
            apply(8'($urandom), 8'($urandom), e, m, 8'($urandom),
                  m == 2'b11 ? "R9" : (e ? "R8" : (m == 2'b00 ? "R3" : (m == 2'b01 ? "R5" : "R6"))));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule